// File: doc/BRIEF.md
# Delayed-Commit Serial CRC-16 Unit

This block computes a 16-bit cyclic redundancy check over a serial bit stream on a synchronous, character-oriented link. Bits arrive one per clock while `in_valid` is high, least significant bit of each character first, and are packed into characters of 5 to 8 bits. A finished character is not folded into the remainder at once. It waits in a one-character holding stage and enters the CRC only when the next character completes.

That one-character delay gives the host a full character time to look at the held character and decide to leave it out of the check. Pulsing `skip_held` while a character is held drops it for good. This suits protocols in which some characters, such as control or fill characters, are not covered by the check.

The generator polynomial and the preset value are chosen at run time. A `clear` pulse starts a new block: it loads the chosen preset and discards both the held character and any part-built character. The current remainder is always visible, together with a flag that is high when the remainder is zero. When the transmitted CRC has been folded in, that flag tells the receiver the block is good.

Top module: `crc_delay_unit`

## Requirements
- R1: After reset, `crc_out` is 16'h0000, `zero_ok` is 1 and `hold_valid` is 0.
- R2: A `clear` pulse loads `crc_out` on the next edge with 16'hFFFF when `preset_ones` is 1, or with 16'h0000 when it is 0. It also discards the held character and any partly assembled character, so `hold_valid` reads 0 afterwards.
- R3: A character is 5 + `len_sel` bits long (`len_sel` 0..3 gives lengths 5..8). Bit i of the character is the i-th valid bit received. `hold_valid` goes high on the edge that accepts the last bit of the character.
- R4: A completed character does not change `crc_out` when it arrives. It is folded in on the edge that completes the next character, and `crc_out` changes on no other edge except a `clear`.
- R5: Each folded bit b updates the remainder c as follows: c = (c << 1) ^ P when c[15] ^ b is 1, and c = c << 1 otherwise. P is 16'h8005 when `poly_sel` is 0 and 16'h1021 when `poly_sel` is 1. A character's bits are folded from bit 0 upward.
- R6: If `skip_held` is high on any edge while `hold_valid` is 1, that held character never enters the CRC. When the next character completes, `crc_out` stays unchanged.
- R7: `zero_ok` is 1 exactly when `crc_out` is 16'h0000. If a message is followed by its remainder, sent most significant remainder bit first, then after the last CRC character has been folded in, `zero_ok` reads 1.
- R8: Cycles with `in_valid` low are ignored. `in_bit` does not matter then, the bit count does not advance, and `crc_out` and `hold_valid` do not change.
- R9: When `clear` and `in_valid` are high on the same edge, `clear` wins. The bit is dropped and the next character starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Load preset and discard held and partial characters |
| preset_ones | input | 1 | Preset choice: 1 = all ones, 0 = all zeros |
| poly_sel | input | 1 | Polynomial: 0 = x^16+x^15+x^2+1, 1 = x^16+x^12+x^5+1 |
| len_sel | input | 2 | Character length minus five |
| in_valid | input | 1 | `in_bit` carries a data bit this cycle |
| in_bit | input | 1 | Serial data bit |
| skip_held | input | 1 | Exclude the currently held character from the CRC |
| crc_out | output | 16 | Current remainder |
| zero_ok | output | 1 | Remainder is zero |
| hold_valid | output | 1 | A character is waiting in the holding stage |

## Verification
A bit counter that slips shows at the ports as `hold_valid` rising one or more valid bits early or late, on the very edge where the character should have closed. A corrupted held character or a lost drop flag stays hidden for a full character time. It surfaces as a wrong `crc_out` only on the edge that closes the following character, so every check on the remainder is timed to that edge. A wrong polynomial or a bad fold order shows up as a wrong remainder on that same edge, and at the end of a block as `zero_ok` failing to rise after a correct trailing CRC.

// File: rtl/crcd_pkg.sv
package crcd_pkg;
  localparam int CRC_W    = 16;
  localparam int CHAR_MAX = 8;
  localparam int CHAR_MIN = 5;
  localparam int CNT_W    = $clog2(CHAR_MAX + 1);
  localparam int IDX_W    = $clog2(CHAR_MAX);
  localparam int LSEL_W   = 2;

  localparam logic [CRC_W-1:0] POLY_A = 16'h8005;
  localparam logic [CRC_W-1:0] POLY_B = 16'h1021;

  function automatic logic [CRC_W-1:0] poly_of(input logic sel);
    return sel ? POLY_B : POLY_A;
  endfunction

  function automatic logic [CNT_W-1:0] len_of(input logic [LSEL_W-1:0] sel);
    return CNT_W'(CHAR_MIN) + CNT_W'(sel);
  endfunction

  // one serial bit through the division register
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic b,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // a whole character, bit 0 first, only the first len bits
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [CHAR_MAX-1:0] data,
                                                input logic [CNT_W-1:0] len,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (i < int'(len)) r = crc_step(r, data[i], poly);
    end
    return r;
  endfunction
endpackage

// File: rtl/crcd_assembler.sv
module crcd_assembler
  import crcd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                in_valid,
  input  logic                in_bit,
  input  logic [CNT_W-1:0]    len,
  output logic                char_done,
  output logic [CHAR_MAX-1:0] char_data,
  output logic [CNT_W-1:0]    char_len
);
  logic [CNT_W-1:0]    cnt_q;
  logic [CHAR_MAX-1:0] shr_q;
  logic [CHAR_MAX-1:0] shr_nxt;
  logic                last_bit;

  always_comb begin
    shr_nxt = shr_q;
    shr_nxt[cnt_q[IDX_W-1:0]] = in_bit;
  end

  assign last_bit  = in_valid && ((cnt_q + CNT_W'(1)) >= len);
  assign char_done = last_bit && !clr;
  assign char_data = shr_nxt;
  assign char_len  = len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      shr_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      shr_q <= '0;
    end else if (in_valid) begin
      if (last_bit) begin
        cnt_q <= '0;
        shr_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        shr_q <= shr_nxt;
      end
    end
  end

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(CHAR_MAX));

  p_idle_no_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(cnt_q));

  p_clear_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/crcd_hold.sv
module crcd_hold
  import crcd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                char_done,
  input  logic [CHAR_MAX-1:0] char_data,
  input  logic [CNT_W-1:0]    char_len,
  input  logic                skip,
  output logic                hold_valid,
  output logic [CHAR_MAX-1:0] held_data,
  output logic [CNT_W-1:0]    held_len,
  output logic                fold_en
);
  logic hold_q;
  logic drop_q;
  logic excluded;

  assign excluded   = drop_q || skip;
  assign fold_en    = char_done && hold_q && !excluded;
  assign hold_valid = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      drop_q    <= 1'b0;
      held_data <= '0;
      held_len  <= '0;
    end else if (clr) begin
      hold_q <= 1'b0;
      drop_q <= 1'b0;
    end else if (char_done) begin
      hold_q    <= 1'b1;
      drop_q    <= 1'b0;
      held_data <= char_data;
      held_len  <= char_len;
    end else if (skip && hold_q) begin
      drop_q <= 1'b1;
    end
  end

  p_hold_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !clr) |=> hold_q);

  p_clear_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hold_q);

  p_drop_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && skip && !clr && !char_done) |=> drop_q);
endmodule

// File: rtl/crcd_accum.sv
module crcd_accum
  import crcd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                preset_ones,
  input  logic                poly_sel,
  input  logic                fold_en,
  input  logic [CHAR_MAX-1:0] data,
  input  logic [CNT_W-1:0]    len,
  output logic [CRC_W-1:0]    crc
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] folded;

  assign folded = crc_fold(crc_q, data, len, poly_of(poly_sel));
  assign crc    = crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (clr)     crc_q <= preset_ones ? '1 : '0;
    else if (fold_en) crc_q <= folded;
  end

  p_clear_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == ($past(preset_ones) ? {CRC_W{1'b1}} : {CRC_W{1'b0}})));

  p_steady_without_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !fold_en) |=> $stable(crc_q));
endmodule

// File: rtl/crc_delay_unit.sv
module crc_delay_unit
  import crcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              preset_ones,
  input  logic              poly_sel,
  input  logic [LSEL_W-1:0] len_sel,
  input  logic              in_valid,
  input  logic              in_bit,
  input  logic              skip_held,
  output logic [CRC_W-1:0]  crc_out,
  output logic              zero_ok,
  output logic              hold_valid
);
  logic                char_done;
  logic [CHAR_MAX-1:0] char_data;
  logic [CNT_W-1:0]    char_len;
  logic [CHAR_MAX-1:0] held_data;
  logic [CNT_W-1:0]    held_len;
  logic                fold_en;

  crcd_assembler u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clear),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .len       (len_of(len_sel)),
    .char_done (char_done),
    .char_data (char_data),
    .char_len  (char_len)
  );

  crcd_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clear),
    .char_done  (char_done),
    .char_data  (char_data),
    .char_len   (char_len),
    .skip       (skip_held),
    .hold_valid (hold_valid),
    .held_data  (held_data),
    .held_len   (held_len),
    .fold_en    (fold_en)
  );

  crcd_accum u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clear),
    .preset_ones (preset_ones),
    .poly_sel    (poly_sel),
    .fold_en     (fold_en),
    .data        (held_data),
    .len         (held_len),
    .crc         (crc_out)
  );

  assign zero_ok = (crc_out == '0);

  p_idle_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !in_valid) |=> ($stable(crc_out) && $stable(hold_valid)));

  p_skip_excludes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && skip_held && !clear) |=> $stable(crc_out));

  p_first_char_no_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_valid && !clear) |=> $stable(crc_out));
endmodule

// File: tb/crc_delay_unit_test.sv
module crc_delay_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        preset_ones = 1'b0;
  logic        poly_sel = 1'b0;
  logic [1:0]  len_sel = 2'd3;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        skip_held = 1'b0;
  logic [15:0] crc_out;
  logic        zero_ok;
  logic        hold_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  crc_delay_unit uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .preset_ones(preset_ones),
    .poly_sel(poly_sel), .len_sel(len_sel), .in_valid(in_valid), .in_bit(in_bit),
    .skip_held(skip_held), .crc_out(crc_out), .zero_ok(zero_ok), .hold_valid(hold_valid)
  );

  // stimulus: {poly, preset, len_sel[1:0], d0[7:0], d1[7:0], skip}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 1'b1, 2'd3, 8'hA5, 8'h3C, 1'b0},
    {1'b1, 1'b1, 2'd3, 8'h12, 8'hFF, 1'b0},
    {1'b1, 1'b0, 2'd0, 8'h1F, 8'h0A, 1'b0},
    {1'b0, 1'b0, 2'd2, 8'h55, 8'h7F, 1'b1},
    {1'b1, 1'b1, 2'd1, 8'h2B, 8'h11, 1'b1},
    {1'b0, 1'b1, 2'd3, 8'h00, 8'h80, 1'b0}
  };

  function automatic logic [15:0] model(input logic [15:0] c, input logic [7:0] d,
                                        input int n, input logic ps);
    logic [16:0] t;
    logic [15:0] p;
    p = ps ? 16'h1021 : 16'h8005;
    for (int i = 0; i < n; i++) begin
      t = {c, 1'b0};
      if (c[15] != d[i]) t = t ^ {1'b1, p};
      c = t[15:0];
    end
    return c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7 - i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic send_char(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit = d[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_clear(input logic ps, input logic po, input logic [1:0] ls);
    @(negedge clk);
    poly_sel = ps;
    preset_ones = po;
    len_sel = ls;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic pulse_skip();
    @(negedge clk);
    skip_held = 1'b1;
    @(negedge clk);
    skip_held = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] pre, e1, e2, c;
    logic [7:0]  d0, d1, a, b;
    int          n;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 crc", crc_out, 16'h0000);
    chk("R1 zero_ok", {15'd0, zero_ok}, 16'd1);
    chk("R1 hold", {15'd0, hold_valid}, 16'd0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      n = 5 + int'(VEC[v][18:17]);
      d0 = VEC[v][16:9] & ((8'd1 << n) - 8'd1);
      d1 = VEC[v][8:1] & ((8'd1 << n) - 8'd1);
      pre = VEC[v][19] ? 16'hFFFF : 16'h0000;
      do_clear(VEC[v][20], VEC[v][19], VEC[v][18:17]);
      chk("R2 preset", crc_out, pre);
      chk("R2 hold cleared", {15'd0, hold_valid}, 16'd0);
      send_char(d0, n);
      chk("R3 hold after char", {15'd0, hold_valid}, 16'd1);
      chk("R4 no fold on arrival", crc_out, pre);
      if (VEC[v][0]) pulse_skip();
      send_char(d1, n);
      e1 = VEC[v][0] ? pre : model(pre, d0, n, VEC[v][20]);
      chk(VEC[v][0] ? "R6 skipped char" : "R4 delayed fold", crc_out, e1);
      send_char(8'h00, n);
      e2 = model(e1, d1, n, VEC[v][20]);
      chk("R5 remainder", crc_out, e2);
      chk("R7 flag", {15'd0, zero_ok}, {15'd0, e2 == 16'h0000});
    end

    // R8: idle cycles ignored, bits counted only when valid
    do_clear(1'b0, 1'b1, 2'd3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_bit = i[0];
    end
    @(negedge clk);
    chk("R8 crc idle", crc_out, 16'hFFFF);
    chk("R8 hold idle", {15'd0, hold_valid}, 16'd0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      in_bit = 1'b0;
    end
    @(negedge clk);
    chk("R8 seven valid bits", {15'd0, hold_valid}, 16'd0);
    send_char(8'h01, 1);
    chk("R3 eighth bit closes", {15'd0, hold_valid}, 16'd1);

    // R7: message followed by its own remainder
    do_clear(1'b1, 1'b1, 2'd3);
    c = model(model(16'hFFFF, 8'h31, 8, 1'b1), 8'h32, 8, 1'b1);
    a = rev8(c[15:8]);
    b = rev8(c[7:0]);
    send_char(8'h31, 8);
    send_char(8'h32, 8);
    send_char(a, 8);
    send_char(b, 8);
    send_char(8'h00, 8);
    chk("R7 residue zero", crc_out, 16'h0000);
    chk("R7 zero_ok", {15'd0, zero_ok}, 16'd1);

    // R9 / R2: clear wins over a valid bit and discards the held char
    do_clear(1'b0, 1'b1, 2'd3);
    send_char(8'hC3, 8);
    @(negedge clk);
    clear = 1'b1;
    in_valid = 1'b1;
    in_bit = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    in_valid = 1'b0;
    chk("R9 preset after clear", crc_out, 16'hFFFF);
    chk("R2 held dropped", {15'd0, hold_valid}, 16'd0);
    send_char(8'h7E, 7);
    chk("R9 count restarted", {15'd0, hold_valid}, 16'd0);
    send_char(8'h00, 1);
    send_char(8'h5A, 8);
    chk("R2 old char discarded", crc_out, model(16'hFFFF, 8'h7E, 8, 1'b0));

    finish_up();
  end
endmodule